// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block lets a design running on a single clock read and write an external asynchronous static RAM of 8K words by 8 bits. The host side uses a request/ready handshake. A request carries an address, write data and a direction flag. Reads return a byte together with a one-cycle valid strobe. The memory side drives the address bus and two chip selects of opposite polarity, an active-low write strobe and an active-low output enable. It also drives an outgoing data bus with its own driver-enable, and it samples an incoming data bus.

Every timing minimum of the memory is given in nanoseconds as a parameter. Each one is turned into a whole number of cycles of the parameter `CLK_PERIOD_NS`: the ceiling of the ratio, and never less than one. All memory-side controls come straight from flops, so no decode glitch can reach the write strobe. Between accesses the memory is held in standby. After a read, the controller waits for the memory's outputs to float before it accepts the next request.

With the default 5 ns clock the counts are as follows:

| Phase | Length |
|---|---|
| Write strobe | 36 cycles (the longest of the write-pulse, address-valid, select-valid and data-setup minimums) |
| Write recovery | 4 cycles, so that the 200 ns write cycle is met |
| Read access | 40 cycles |
| Float wait after a read | 12 cycles |

Top module: `asram_ctrl`

## Requirements
- R1: Whenever `req_ready` is high, the memory is in standby with the bus released: `mem_cs_n`=1, `mem_cs`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0. Right after reset, `req_ready` is 1 and `rd_valid` is 0.
- R2: A write is accepted on a clock edge where `req_valid`, `req_ready` and `req_write`=1 are all high. For the next N_WP cycles `mem_we_n` is 0, both chip selects are active, `mem_oe_n` is 1 and the data drivers are on. N_WP is the largest of ceil(T_WP), ceil(T_AW), ceil(T_CW) and ceil(T_DW) in clock periods, which is 36 with the defaults.
- R3: After the write strobe rises, address, chip selects and driven data stay unchanged for N_WR = max(1, ceil(T_WC) − N_WP) cycles (4 with the defaults). `req_ready` then returns high N_WP+N_WR cycles after acceptance.
- R4: A read is accepted with `req_write`=0. For the next N_RD = max(ceil(T_AA), ceil(T_RC)) cycles (40 with the defaults), `mem_oe_n` is 0, `mem_we_n` is 1, both selects are active and the drivers are off.
- R5: On the clock edge that ends the read access, `mem_dq_in` is captured into `rd_data`. `rd_valid` is high for exactly one cycle, which is the cycle at index N_RD after acceptance.
- R6: After a read access, the controller waits N_FL = max(ceil(T_OHZ), ceil(T_HZ)) cycles (12 with the defaults) in standby with the drivers off, and only then raises `req_ready`. A read therefore keeps the block busy for 52 cycles.
- R7: `req_ready` stays low for the whole memory cycle. A request presented while it is low has no effect on the memory contents.
- R8: The data drivers are never on while `mem_oe_n` is 0. A write strobe occurs only while both selects are active and the drivers are on.
- R9: Data written to an address is returned by a later read of that address, for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` new |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Driver enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data bus as seen from the memory |

## Verification
All results are counted from the clock edge that accepts a request.

- **Write:** the write strobe is low on cycles 0 to 35 after that edge, and `req_ready` returns on cycle 40.
- **Read:** the output enable is low on cycles 0 to 39, `rd_valid` appears on cycle 40, and `req_ready` returns on cycle 52.

The bench samples on falling edges and tags each sample with its cycle index from the accepting edge, so every count and position is compared exactly. Its memory model returns a poison byte until 39 edges of read mode have passed, so a capture that comes too early returns a wrong value. Because of this, the sweep over all addresses checks both the timing and the data path.

// File: rtl/asram_ctrl.sv
module asram_ctrl #(
  parameter int CLK_PERIOD_NS = 5,
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int T_WC_NS       = 200,
  parameter int T_WP_NS       = 150,
  parameter int T_AW_NS       = 180,
  parameter int T_CW_NS       = 180,
  parameter int T_DW_NS       = 100,
  parameter int T_RC_NS       = 200,
  parameter int T_AA_NS       = 200,
  parameter int T_OHZ_NS      = 40,
  parameter int T_HZ_NS       = 60
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int N_WP  = max2(max2(cyc(T_WP_NS), cyc(T_AW_NS)), max2(cyc(T_CW_NS), cyc(T_DW_NS)));
  localparam int N_WR  = max2(1, cyc(T_WC_NS) - N_WP);
  localparam int N_RD  = max2(cyc(T_AA_NS), cyc(T_RC_NS));
  localparam int N_FL  = max2(cyc(T_OHZ_NS), cyc(T_HZ_NS));
  localparam int N_MAX = max2(max2(N_WP, N_WR), max2(N_RD, N_FL));
  localparam int CW    = $clog2(N_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_WPULSE, S_WREC, S_READ, S_FLOAT} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic            ce_on;
  logic            last;

  assign last      = (cnt == '0);
  assign req_ready = (state == S_IDLE);
  assign mem_cs_n  = ~ce_on;
  assign mem_cs    = ce_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      ce_on      <= 1'b0;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          ce_on    <= 1'b1;
          if (req_write) begin
            mem_dq_out <= req_wdata;
            mem_dq_oe  <= 1'b1;
            mem_we_n   <= 1'b0;
            cnt        <= CW'(N_WP - 1);
            state      <= S_WPULSE;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= CW'(N_RD - 1);
            state    <= S_READ;
          end
        end
        S_WPULSE: if (last) begin
          mem_we_n <= 1'b1;
          cnt      <= CW'(N_WR - 1);
          state    <= S_WREC;
        end else cnt <= cnt - 1'b1;
        S_WREC: if (last) begin
          ce_on     <= 1'b0;
          mem_dq_oe <= 1'b0;
          state     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        S_READ: if (last) begin
          rd_data  <= mem_dq_in;
          rd_valid <= 1'b1;
          mem_oe_n <= 1'b1;
          ce_on    <= 1'b0;
          cnt      <= CW'(N_FL - 1);
          state    <= S_FLOAT;
        end else cnt <= cnt - 1'b1;
        S_FLOAT: if (last) state <= S_IDLE;
        else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_standby_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r8_no_drive_into_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  a_r2_strobe_in_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs && mem_oe_n && mem_dq_oe));

  a_r3_addr_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  a_r5_single_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  a_r6_valid_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!req_ready && mem_oe_n && !mem_dq_oe));

endmodule

// File: tb/asram_ctrl_bench.sv
module asram_ctrl_bench;
  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int TCK = 5;
  localparam int NWP = (180 + TCK - 1) / TCK;
  localparam int NWR = (200 + TCK - 1) / TCK - NWP;
  localparam int NRD = (200 + TCK - 1) / TCK;
  localparam int NFL = (60 + TCK - 1) / TCK;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
  logic [AW-1:0] mem_addr;

  int checks = 0;
  int failures = 0;
  int viol = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asram_ctrl #(.CLK_PERIOD_NS(TCK), .ADDR_W(AW), .DATA_W(DW)) u_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  logic [DW-1:0] mem [1<<AW];
  int age = 0;
  logic rd_mode;
  assign rd_mode   = !mem_cs_n && mem_cs && !mem_oe_n && mem_we_n;
  assign mem_dq_in = (rd_mode && age >= NRD - 1) ? mem[mem_addr] : 8'hEE;

  always @(posedge clk) age <= rd_mode ? age + 1 : 0;

  always @(negedge clk) begin
    if (!mem_we_n && !mem_cs_n && mem_cs && mem_dq_oe) mem[mem_addr] <= mem_dq_out;
    if (rst_n) begin
      if (req_ready && !(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe)) viol++; // R1
      if (mem_dq_oe && !mem_oe_n) viol++;                                                 // R8
      if (!mem_we_n && !(mem_cs && !mem_cs_n && mem_dq_oe && mem_oe_n)) viol++;             // R8
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return DW'((a * 37 + 11 + s * 101) & 8'hFF);
  endfunction

  // Issues one request; the negedge index k counts from the accepting edge.
  task automatic xfer(input bit wr, input int a, input logic [DW-1:0] d, input bit inject,
                      output int busy, output int lowcnt, output int lastlow,
                      output int rvpos, output int rvcnt, output logic [DW-1:0] rdat);
    int k;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 0; lowcnt = 0; lastlow = -1; rvpos = -1; rvcnt = 0; rdat = '0;
    while (!req_ready && k < 200) begin
      if (wr ? !mem_we_n : !mem_oe_n) begin lowcnt++; lastlow = k; end
      if (rd_valid) begin rvpos = k; rvcnt++; rdat = rd_data; end
      if (inject && k == 10) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a ^ 1); req_wdata = 8'h3C;
      end
      if (inject && k == 20) req_valid = 1'b0;
      k++;
      @(negedge clk);
    end
    busy = k;
  endtask

  initial begin
    int busy, lc, ll, rp, rc;
    logic [DW-1:0] rd;
    repeat (3) @(negedge clk);
    chk(req_ready === 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(rd_valid === 1'b0, "R1 reset rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 standby", int'(mem_dq_oe), 0);

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < (1 << AW); a++) begin
        xfer(1'b1, a, pat(a, s), 1'b0, busy, lc, ll, rp, rc, rd);
        chk(lc == NWP, "R2 strobe length", lc, NWP);
        chk(ll == NWP - 1, "R2 strobe position", ll, NWP - 1);
        chk(busy == NWP + NWR, "R3 write busy", busy, NWP + NWR);
      end
      for (int a = 0; a < (1 << AW); a++) begin
        xfer(1'b0, a, '0, 1'b0, busy, lc, ll, rp, rc, rd);
        chk(lc == NRD && ll == NRD - 1, "R4 read enable window", lc, NRD);
        chk(rp == NRD && rc == 1, "R5 valid strobe", rp, NRD);
        chk(busy == NRD + NFL, "R6 read busy", busy, NRD + NFL);
        chk(rd == pat(a, s), "R9 read-back", int'(rd), int'(pat(a, s)));
      end
    end

    // R7: a request raised mid-write must not reach the memory.
    xfer(1'b1, 4, 8'hA5, 1'b1, busy, lc, ll, rp, rc, rd);
    chk(busy == NWP + NWR, "R7 busy unchanged", busy, NWP + NWR);
    xfer(1'b0, 5, '0, 1'b0, busy, lc, ll, rp, rc, rd);
    chk(rd == pat(5, 1), "R7 ignored request", int'(rd), int'(pat(5, 1)));
    xfer(1'b0, 4, '0, 1'b0, busy, lc, ll, rp, rc, rd);
    chk(rd == 8'hA5, "R9 data after ignore", int'(rd), 8'hA5);

    chk(viol == 0, "R1 R8 bus invariants", viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule